// File: doc/BRIEF.md
# Byte-Wide Conversion Result Port

This block holds the latest 14-bit result of an integrating converter (12 magnitude bits, a polarity bit and an over-range bit). It hands that result to a host as two bytes. In direct mode the host reads the bytes as if from a bus peripheral. A master enable and two active-low byte enables, all inputs, gate the tri-state data pins. The pins are modelled here as data vectors plus output-enable signals.

In handshake mode the three control pins turn into outputs. The block then pushes the high byte and then the low byte to a serial transmitter. Each byte waits for a ready input from that transmitter, and a one-clock active-low load strobe marks it. A transfer starts in one of two ways. A rising edge on the mode input starts one at once with the data already held. While the mode input stays high, every new conversion result starts one. A test input forces every data bit high. The converter sequencer supplies a single-cycle latch pulse, and only that pulse updates the held result.

Top module: `adc_byte_port`

## Requirements
- R1: After reset the result register is zero, no control pin is driven (all three output enables low, output values 1) and no data byte is driven.
- R2: In direct mode (synchronised mode low and no transfer running), a high level on `ce_ld_n_i` disables both data bytes whatever the byte enables are.
- R3: In direct mode, with `ce_ld_n_i` low and `lben_n_i` low, `lo_byte_oe_o` is 1 in the same cycle. `lo_byte_o` carries magnitude bits 7..0.
- R4: In direct mode, with `ce_ld_n_i` low and `hben_n_i` low, `hi_byte_oe_o` is 1. `hi_byte_o` carries polarity in bit 5 (1 = positive), over-range in bit 4 (1 = over range) and magnitude bits 11..8 in bits 3..0.
- R5: The result register loads `{pol_i, ovr_i, mag_i}` at the edge where `latch_i` is 1, but only when no transfer is running. A latch pulse during a transfer is ignored.
- R6: While the synchronised mode is high or a transfer runs, all three control output enables are 1. Between transfers the flags and the strobe sit at 1 and no data byte is driven.
- R7: `mode_i` passes through a two-flop synchroniser. A rising edge applied before clock edge k starts a transfer at clock edge k+2, using the held data.
- R8: While the synchronised mode is high and the block is idle, a latch pulse loads the new result and starts a transfer at the same edge.
- R9: A transfer first drives the high byte with `hben_n_o` low, then the low byte with `lben_n_o` low. Each byte waits in its flag phase until `send_i` is 1 at an edge. Then comes one cycle with `ce_ld_n_o` low. After the low-byte strobe the block is idle.
- R10: While `send_i` is 0 the transfer stays in its flag phase, and the strobe is not pulsed.
- R11: `test_n_i` low forces every bit of both data bytes to 1 and leaves the output enables unchanged.
- R12: Once started, a transfer runs to its end even if the mode drops. After it ends with the mode low, the pins return to direct mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| latch_i | input | 1 | Single-cycle result latch pulse from the converter sequencer |
| mag_i | input | MAG_W | Magnitude bits of the new result |
| pol_i | input | 1 | Polarity of the new result, 1 = positive |
| ovr_i | input | 1 | Over-range flag of the new result |
| mode_i | input | 1 | Mode select, asynchronous; low = direct, high/edge = handshake |
| send_i | input | 1 | Receiver ready |
| test_n_i | input | 1 | Test override, low forces data bits to 1 |
| ce_ld_n_i | input | 1 | Master enable input (direct mode) |
| ce_ld_n_o | output | 1 | Load strobe output (handshake mode) |
| ce_ld_oe_o | output | 1 | Output enable of the enable/strobe pin |
| hben_n_i | input | 1 | High byte enable input (direct mode) |
| hben_n_o | output | 1 | High byte flag output (handshake mode) |
| hben_oe_o | output | 1 | Output enable of the high byte pin |
| lben_n_i | input | 1 | Low byte enable input (direct mode) |
| lben_n_o | output | 1 | Low byte flag output (handshake mode) |
| lben_oe_o | output | 1 | Output enable of the low byte pin |
| lo_byte_o | output | LO_W | Low data byte |
| lo_byte_oe_o | output | 1 | Low data byte output enable |
| hi_byte_o | output | MAG_W-LO_W+2 | High data byte: polarity, over-range, upper magnitude |
| hi_byte_oe_o | output | 1 | High data byte output enable |

## Verification
The bench builds the block with its defaults: a 12-bit magnitude, an 8-bit low byte and a two-stage mode synchroniser. With these values the six-bit high byte puts polarity and over-range in bits 5 and 4. The three-cycle delay from mode pin to transfer start can then be counted exactly. Short transfers let a single run cover several complete handshakes. These include stalls on a low ready input, a mode pulse of one clock, a mode drop during a transfer and a latch pulse that lands while a transfer is running.

// File: rtl/adc_byte_port_pkg.sv
package adc_byte_port_pkg;

    typedef enum logic [2:0] {
        HS_IDLE    = 3'd0,
        HS_WAIT_HI = 3'd1,
        HS_LOAD_HI = 3'd2,
        HS_WAIT_LO = 3'd3,
        HS_LOAD_LO = 3'd4
    } hs_state_e;

    typedef struct packed {
        hs_state_e st;
    } hs_regs_t;

endpackage

// File: rtl/abp_mode_sync.sv
module abp_mode_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_i,
    output logic mode_s_o,
    output logic mode_rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_regs_t;

    sync_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.chain = {cur_q.chain[STAGES-2:0], mode_i};
        nxt_d.prev  = cur_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign mode_s_o    = cur_q.chain[STAGES-1];
    assign mode_rise_o = cur_q.chain[STAGES-1] & ~cur_q.prev;

    // R7: a detected edge lasts exactly one cycle
    a_r7_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        mode_rise_o |=> !mode_rise_o);

endmodule

// File: rtl/abp_result_reg.sv
module abp_result_reg #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         latch_i,
    input  logic         busy_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] data_o
);
    typedef struct packed {
        logic [W-1:0] res;
    } res_regs_t;

    res_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (latch_i && !busy_i) nxt_d.res = data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign data_o = cur_q.res;

    // R5: held result is frozen while a transfer runs
    a_r5_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(data_o));
    // R5: an accepted latch pulse lands in the register
    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_i && !busy_i) |=> (data_o == $past(data_i)));

endmodule

// File: rtl/abp_hs_seq.sv
module abp_hs_seq
    import adc_byte_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      send_i,
    output hs_state_e state_o,
    output logic      busy_o
);
    hs_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            HS_IDLE:    if (start_i) nxt_d.st = HS_WAIT_HI;
            HS_WAIT_HI: if (send_i)  nxt_d.st = HS_LOAD_HI;
            HS_LOAD_HI:              nxt_d.st = HS_WAIT_LO;
            HS_WAIT_LO: if (send_i)  nxt_d.st = HS_LOAD_LO;
            HS_LOAD_LO:              nxt_d.st = HS_IDLE;
            default:                 nxt_d.st = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: HS_IDLE};
        else        cur_q <= nxt_d;
    end

    assign state_o = cur_q.st;
    assign busy_o  = (cur_q.st != HS_IDLE);

    // R10: no ready, no progress
    a_r10_stall_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == HS_WAIT_HI && !send_i) |=> (state_o == HS_WAIT_HI));
    a_r10_stall_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == HS_WAIT_LO && !send_i) |=> (state_o == HS_WAIT_LO));
    // R9: high byte is followed by low byte, then idle
    a_r9_hi_then_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == HS_LOAD_HI) |=> (state_o == HS_WAIT_LO));
    a_r9_lo_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == HS_LOAD_LO) |=> (state_o == HS_IDLE));

endmodule

// File: rtl/abp_pin_mux.sv
module abp_pin_mux
    import adc_byte_port_pkg::*;
#(
    parameter int MAG_W = 12,
    parameter int LO_W  = 8,
    localparam int HI_W = MAG_W - LO_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_s_i,
    input  hs_state_e        state_i,
    input  logic [MAG_W+1:0] res_i,
    input  logic             test_n_i,
    input  logic             ce_ld_n_i,
    input  logic             hben_n_i,
    input  logic             lben_n_i,
    output logic             ce_ld_n_o,
    output logic             ce_ld_oe_o,
    output logic             hben_n_o,
    output logic             hben_oe_o,
    output logic             lben_n_o,
    output logic             lben_oe_o,
    output logic [LO_W-1:0]  lo_byte_o,
    output logic             lo_byte_oe_o,
    output logic [HI_W-1:0]  hi_byte_o,
    output logic             hi_byte_oe_o
);
    logic hs_active;
    logic hi_phase, lo_phase, strobe;

    always_comb begin
        hs_active = mode_s_i || (state_i != HS_IDLE);
        hi_phase  = (state_i == HS_WAIT_HI) || (state_i == HS_LOAD_HI);
        lo_phase  = (state_i == HS_WAIT_LO) || (state_i == HS_LOAD_LO);
        strobe    = (state_i == HS_LOAD_HI) || (state_i == HS_LOAD_LO);

        if (test_n_i) begin
            lo_byte_o = res_i[LO_W-1:0];
            hi_byte_o = res_i[MAG_W+1:LO_W];
        end else begin
            lo_byte_o = '1;
            hi_byte_o = '1;
        end

        if (hs_active) begin
            ce_ld_oe_o   = 1'b1;
            hben_oe_o    = 1'b1;
            lben_oe_o    = 1'b1;
            ce_ld_n_o    = ~strobe;
            hben_n_o     = ~hi_phase;
            lben_n_o     = ~lo_phase;
            hi_byte_oe_o = hi_phase;
            lo_byte_oe_o = lo_phase;
        end else begin
            ce_ld_oe_o   = 1'b0;
            hben_oe_o    = 1'b0;
            lben_oe_o    = 1'b0;
            ce_ld_n_o    = 1'b1;
            hben_n_o     = 1'b1;
            lben_n_o     = 1'b1;
            hi_byte_oe_o = ~ce_ld_n_i & ~hben_n_i;
            lo_byte_oe_o = ~ce_ld_n_i & ~lben_n_i;
        end
    end

    // R9: load strobe is a single clock low
    a_r9_strobe_one: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_ld_oe_o && !ce_ld_n_o) |=> ce_ld_n_o);
    // R9: only one byte at a time in handshake mode
    a_r9_one_byte: assert property (@(posedge clk) disable iff (!rst_n)
        ce_ld_oe_o |-> !(lo_byte_oe_o && hi_byte_oe_o));
    // R2: master enable high silences both bytes in direct mode
    a_r2_master_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_ld_oe_o && ce_ld_n_i) |-> (!lo_byte_oe_o && !hi_byte_oe_o));
    // R6: synchronised mode high drives all control pins
    a_r6_pins_driven: assert property (@(posedge clk) disable iff (!rst_n)
        mode_s_i |-> (ce_ld_oe_o && hben_oe_o && lben_oe_o));

endmodule

// File: rtl/adc_byte_port.sv
module adc_byte_port
    import adc_byte_port_pkg::*;
#(
    parameter int MAG_W       = 12,
    parameter int LO_W        = 8,
    parameter int SYNC_STAGES = 2,
    localparam int HI_W       = MAG_W - LO_W + 2,
    localparam int RES_W      = MAG_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             latch_i,
    input  logic [MAG_W-1:0] mag_i,
    input  logic             pol_i,
    input  logic             ovr_i,
    input  logic             mode_i,
    input  logic             send_i,
    input  logic             test_n_i,
    input  logic             ce_ld_n_i,
    output logic             ce_ld_n_o,
    output logic             ce_ld_oe_o,
    input  logic             hben_n_i,
    output logic             hben_n_o,
    output logic             hben_oe_o,
    input  logic             lben_n_i,
    output logic             lben_n_o,
    output logic             lben_oe_o,
    output logic [LO_W-1:0]  lo_byte_o,
    output logic             lo_byte_oe_o,
    output logic [HI_W-1:0]  hi_byte_o,
    output logic             hi_byte_oe_o
);
    logic             mode_s, mode_rise, busy, start;
    logic [RES_W-1:0] res;
    hs_state_e        state;

    abp_mode_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .mode_s_o    (mode_s),
        .mode_rise_o (mode_rise)
    );

    abp_result_reg #(.W(RES_W)) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .latch_i (latch_i),
        .busy_i  (busy),
        .data_i  ({pol_i, ovr_i, mag_i}),
        .data_o  (res)
    );

    assign start = mode_rise || (latch_i && mode_s);

    abp_hs_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .send_i  (send_i),
        .state_o (state),
        .busy_o  (busy)
    );

    abp_pin_mux #(.MAG_W(MAG_W), .LO_W(LO_W)) u_mux (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_s_i     (mode_s),
        .state_i      (state),
        .res_i        (res),
        .test_n_i     (test_n_i),
        .ce_ld_n_i    (ce_ld_n_i),
        .hben_n_i     (hben_n_i),
        .lben_n_i     (lben_n_i),
        .ce_ld_n_o    (ce_ld_n_o),
        .ce_ld_oe_o   (ce_ld_oe_o),
        .hben_n_o     (hben_n_o),
        .hben_oe_o    (hben_oe_o),
        .lben_n_o     (lben_n_o),
        .lben_oe_o    (lben_oe_o),
        .lo_byte_o    (lo_byte_o),
        .lo_byte_oe_o (lo_byte_oe_o),
        .hi_byte_o    (hi_byte_o),
        .hi_byte_oe_o (hi_byte_oe_o)
    );

    // R12: a running transfer is never abandoned before its low byte
    a_r12_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state != HS_LOAD_LO) |=> busy);
    // R8: a latch while mode is high and idle begins a transfer
    a_r8_latch_start: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_i && mode_s && !busy) |=> (state == HS_WAIT_HI));

endmodule

// File: tb/adc_byte_port_test.sv
module adc_byte_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        latch_i = 1'b0;
    logic [11:0] mag_i = '0;
    logic        pol_i = 1'b0, ovr_i = 1'b0;
    logic        mode_i = 1'b0, send_i = 1'b0, test_n_i = 1'b1;
    logic        ce_ld_n_i = 1'b1, hben_n_i = 1'b1, lben_n_i = 1'b1;
    logic        ce_ld_n_o, ce_ld_oe_o, hben_n_o, hben_oe_o, lben_n_o, lben_oe_o;
    logic [7:0]  lo_byte_o;
    logic        lo_byte_oe_o;
    logic [5:0]  hi_byte_o;
    logic        hi_byte_oe_o;

    int    checks = 0, fails = 0, cyc = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    adc_byte_port uut (.*);

    // behavioural reference: sync delay, transfer phase, held result
    int          m_sync[$];
    int          m_prev, m_phase;
    logic [13:0] m_res;

    initial begin
        m_sync = '{0, 0};
        m_prev = 0; m_phase = 0; m_res = '0;
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sync = '{0, 0}; m_prev = 0; m_phase = 0; m_res = '0;
        end else begin
            int ms;
            bit rise, go;
            ms   = m_sync[1];
            rise = (ms == 1) && (m_prev == 0);
            go   = (m_phase == 0) && (rise || (latch_i && ms == 1));
            if (m_phase == 0 && latch_i) m_res = {pol_i, ovr_i, mag_i};
            case (m_phase)
                0: m_phase = go ? 1 : 0;
                1: m_phase = send_i ? 2 : 1;
                2: m_phase = 3;
                3: m_phase = send_i ? 4 : 3;
                default: m_phase = 0;
            endcase
            m_prev = ms;
            void'(m_sync.pop_back());
            m_sync.push_front(int'(mode_i));
        end
    end

    task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n || cur_req == "R1") begin
            bit hs;
            logic [7:0] e_lo;
            logic [5:0] e_hi;
            hs   = (m_sync[1] == 1) || (m_phase != 0);
            e_lo = test_n_i ? m_res[7:0]  : 8'hFF;
            e_hi = test_n_i ? m_res[13:8] : 6'h3F;
            chk("lo_byte", {8'h0, lo_byte_o}, {8'h0, e_lo});
            chk("hi_byte", {10'h0, hi_byte_o}, {10'h0, e_hi});
            chk("ctrl_oe", {13'h0, ce_ld_oe_o, hben_oe_o, lben_oe_o},
                {13'h0, hs, hs, hs});
            if (hs) begin
                chk("ctrl_val", {13'h0, ce_ld_n_o, hben_n_o, lben_n_o},
                    {13'h0, !(m_phase == 2 || m_phase == 4),
                     !(m_phase == 1 || m_phase == 2), !(m_phase == 3 || m_phase == 4)});
                chk("byte_oe", {14'h0, hi_byte_oe_o, lo_byte_oe_o},
                    {14'h0, (m_phase == 1 || m_phase == 2), (m_phase == 3 || m_phase == 4)});
            end else begin
                chk("ctrl_val", {13'h0, ce_ld_n_o, hben_n_o, lben_n_o}, 16'h7);
                chk("byte_oe", {14'h0, hi_byte_oe_o, lo_byte_oe_o},
                    {14'h0, !ce_ld_n_i && !hben_n_i, !ce_ld_n_i && !lben_n_i});
            end
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic latch(logic [11:0] m, logic p, logic o);
        mag_i = m; pol_i = p; ovr_i = o; latch_i = 1'b1;
        step(1);
        latch_i = 1'b0; mag_i = '0; pol_i = 1'b0; ovr_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog expired after %0d cycles", cyc);
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        step(3);
        rst_n = 1'b1;
        step(2);
        // R5: load in direct mode
        cur_req = "R5";
        latch(12'hA5C, 1'b1, 1'b0);
        step(2);
        // R2: master enable high masks byte enables
        cur_req = "R2";
        hben_n_i = 1'b0; lben_n_i = 1'b0; ce_ld_n_i = 1'b1;
        step(3);
        // R3: low byte
        cur_req = "R3";
        ce_ld_n_i = 1'b0; hben_n_i = 1'b1; lben_n_i = 1'b0;
        step(2);
        // R4: high byte, polarity bit 5, over-range bit 4
        cur_req = "R4";
        hben_n_i = 1'b0; lben_n_i = 1'b1;
        step(2);
        latch(12'h123, 1'b0, 1'b1);
        step(2);
        // R11: test override
        cur_req = "R11";
        test_n_i = 1'b0; lben_n_i = 1'b0;
        step(3);
        test_n_i = 1'b1;
        ce_ld_n_i = 1'b1; hben_n_i = 1'b1; lben_n_i = 1'b1;
        step(1);
        // R7: one-clock mode pulse, receiver ready
        cur_req = "R7";
        send_i = 1'b1;
        mode_i = 1'b1; step(1); mode_i = 1'b0;
        step(10);
        // R10: stalls on send low in both flag phases
        cur_req = "R10";
        send_i = 1'b0;
        mode_i = 1'b1; step(1); mode_i = 1'b0;
        step(6);
        send_i = 1'b1; step(1); send_i = 1'b0;
        step(5);
        send_i = 1'b1;
        step(4);
        // R6: steady mode high, idle pins driven
        cur_req = "R6";
        mode_i = 1'b1;
        step(12);
        // R8: latch with mode high starts a transfer; R5: latch while busy ignored
        cur_req = "R8";
        send_i = 1'b0;
        latch(12'hFA7, 1'b1, 1'b1);
        step(1);
        cur_req = "R5";
        latch(12'h0FF, 1'b0, 1'b0);
        step(2);
        send_i = 1'b1;
        step(6);
        // R12: mode drops mid-transfer, transfer completes, then direct mode
        cur_req = "R12";
        send_i = 1'b0;
        latch(12'h555, 1'b0, 1'b1);
        mode_i = 1'b0;
        step(5);
        send_i = 1'b1;
        step(6);
        ce_ld_n_i = 1'b0; lben_n_i = 1'b0; hben_n_i = 1'b0;
        step(3);
        // R9: one more full handshake checked phase by phase
        cur_req = "R9";
        mode_i = 1'b1; step(1); mode_i = 1'b0;
        step(10);
        finish_run();
    end
endmodule